// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital side of a 16-bit serial-input digital-to-analog converter. A host shifts one data word over three wires: an active-low frame select, a serial clock and a data line. The word arrives most significant bit first and goes into an input shift register. When the frame closes, the word moves into the converter latch, whose contents appear on a parallel code bus. That bus feeds the resistor ladder, which sits outside this block.

An active-low load strobe sets how the latch is updated. If the strobe is held low, the latch takes the word at the moment the frame select is released. If the strobe is held high while the frame loads, the word waits in a holding register until the strobe falls after the frame has ended. A frame that does not carry exactly 16 clock edges is thrown away and raises a sticky error flag. Reset clears the latch to code 0x0000. In unipolar use that code means zero output. In offset-binary bipolar use it means negative full scale, with 0x8000 as zero.

All four serial lines are resynchronised with two flops into a fast system clock. That clock must run at least four times faster than the serial clock. A one-cycle strobe marks every write to the latch.

Top module: `sdac_front`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_code` is 0x0000, `frame_err` is 0 and `dac_update` is 0.
- R2: While `sel_n` is low, each rising edge of `ser_clk` shifts `ser_din` into the input register. The first bit shifted becomes bit 15 of the word and the last becomes bit 0.
- R3: If `sel_n` rises after exactly 16 clock edges and `load_n` is low, `dac_code` takes the word.
- R4: If `sel_n` rises after any edge count other than 16 (fewer or more), the word is dropped and `dac_code` is unchanged. `frame_err` goes to 1 and stays at 1 until reset.
- R5: If `sel_n` rises after exactly 16 edges and `load_n` is high, the word is held as pending and `dac_code` is unchanged. A later falling edge of `load_n`, while `sel_n` is high, copies the pending word into `dac_code`.
- R6: A complete frame that closes with `load_n` high replaces any word that is already pending.
- R7: A falling edge of `load_n` has no effect on `dac_code` when no word is pending, or when it occurs while `sel_n` is low.
- R8: `dac_update` pulses high for exactly one system clock on every latch write, and `dac_code` never changes without that pulse.
- R9: If a fall of `load_n` coincides with the release of `sel_n`, the new word is written directly. If a word was pending, that word is written first and the new word is written on the following cycle, giving two pulses.
- R10: Serial clock edges while `sel_n` is high do not shift the register and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load strobe for the deferred update |
| dac_code | output | 16 | Converter latch contents |
| dac_update | output | 1 | One-cycle pulse on each latch write |
| frame_err | output | 1 | Sticky flag for a badly framed word |

## Verification
Two latch writes can fall on adjacent cycles. This happens when the release of a pending word and a direct write meet: `load_n` falls at the same instant that `sel_n` rises. The bench forces this by driving both pins in the same clock phase, once with no pending word and once with one. It expects the final code to be the new word in both runs, with one update pulse in the first run and two in the second. The pulse counts are taken from the port, and the random phase keeps mixing deferred and direct writes with bad frames.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_BITS = 16;
  localparam int SYNC_DEPTH = 2;
  localparam int N_LINES = 4;
  localparam int L_SEL  = 0;
  localparam int L_SCK  = 1;
  localparam int L_DIN  = 2;
  localparam int L_LOAD = 3;
  // Idle levels: select high, load high, clock and data low.
  localparam logic [N_LINES-1:0] LINE_IDLE = 4'b1001;

  function automatic logic frame_complete(input int unsigned edges, input int unsigned bits);
    return edges == bits;
  endfunction
endpackage

// File: rtl/sdac_line_sync.sv
module sdac_line_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int PW = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [PW-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {PW{IDLE[i]}};
      else        pipe <= {pipe[PW-2:0], pin[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[i] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16,
  localparam int CNT_MAX = WORD_W + 1,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              din_lvl,
  output logic              word_valid,
  output logic              frame_bad,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              good_count;

  assign good_count = sdac_pkg::frame_complete(32'(cnt), 32'(WORD_W));
  assign word = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      frame_bad  <= 1'b0;
    end else begin
      word_valid <= sel_rise && good_count;
      frame_bad  <= sel_rise && !good_count;
      if (sel_fall) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (!sel_lvl && sck_rise) begin
        shreg <= {shreg[WORD_W-2:0], din_lvl};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: the edge counter saturates one past a full word
  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
  // R10: no shifting while the frame select is high
  p_idle_no_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lvl && sck_rise) |=> $stable(shreg));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  input  logic              load_lvl,
  input  logic              load_fall,
  input  logic              sel_lvl,
  output logic [WORD_W-1:0] dac_code,
  output logic              dac_update
);
  logic [WORD_W-1:0] hold;
  logic              pending;
  logic              direct_wr;
  logic              release_wr;

  assign direct_wr  = word_valid && !load_lvl;
  assign release_wr = load_fall && sel_lvl && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= '0;
      dac_update <= 1'b0;
      hold       <= '0;
      pending    <= 1'b0;
    end else begin
      dac_update <= direct_wr || release_wr;
      if (direct_wr) begin
        dac_code <= word;
        pending  <= 1'b0;
      end else if (release_wr) begin
        dac_code <= hold;
        pending  <= 1'b0;
      end
      if (word_valid && load_lvl) begin
        hold    <= word;
        pending <= 1'b1;
      end
    end
  end

  // R8: the code moves only together with the update pulse
  p_code_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> dac_update);
  // R3: a good frame with load low lands on the next cycle
  p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !load_lvl) |=> (dac_update && dac_code == $past(word)));
  // R5: a load fall with select high releases the pending word
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && sel_lvl && pending) |=> (dac_update && !pending));
  // R7: a pending word survives until something consumes it
  p_pend_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !load_fall && !word_valid) |=> pending);
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int WORD_W = sdac_pkg::WORD_BITS,
  parameter int SYNC_STAGES = sdac_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              load_n,
  output logic [WORD_W-1:0] dac_code,
  output logic              dac_update,
  output logic              frame_err
);
  import sdac_pkg::*;

  logic [N_LINES-1:0] pins, lvl, rise, fall;
  logic               word_valid, frame_bad;
  logic [WORD_W-1:0]  word;

  assign pins[L_SEL]  = sel_n;
  assign pins[L_SCK]  = ser_clk;
  assign pins[L_DIN]  = ser_din;
  assign pins[L_LOAD] = load_n;

  sdac_line_sync #(.N(N_LINES), .STAGES(SYNC_STAGES), .IDLE(LINE_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pins), .lvl(lvl), .rise(rise), .fall(fall));

  sdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(lvl[L_SEL]), .sel_fall(fall[L_SEL]), .sel_rise(rise[L_SEL]),
    .sck_rise(rise[L_SCK]), .din_lvl(lvl[L_DIN]),
    .word_valid(word_valid), .frame_bad(frame_bad), .word(word));

  sdac_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
    .load_lvl(lvl[L_LOAD]), .load_fall(fall[L_LOAD]), .sel_lvl(lvl[L_SEL]),
    .dac_code(dac_code), .dac_update(dac_update));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame_err <= 1'b0;
    else if (frame_bad) frame_err <= 1'b1;
  end

  // R4: a bad frame raises the flag, and the flag stays up
  p_bad_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> frame_err);
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

// File: tb/sdac_front_bench.sv
module sdac_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, load_n = 1'b1;
  logic [15:0] dac_code;
  logic        dac_update, frame_err;

  int tests = 0, fails = 0, upd_seen = 0;
  logic [15:0] m_code = '0, m_hold = '0;
  logic        m_pend = 1'b0, m_err = 1'b0;
  int          m_upd = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sdac_front u_sdac_front (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .load_n(load_n), .dac_code(dac_code), .dac_update(dac_update),
    .frame_err(frame_err));

  always @(negedge clk) if (rst_n && dac_update) upd_seen++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " code"}, 32'(dac_code), 32'(m_code));
    check({tag, " err"}, 32'(frame_err), 32'(m_err));
    check({tag, " updates"}, 32'(upd_seen), 32'(m_upd));
  endtask

  // Bench model of a frame closing
  function automatic void model_close(input logic [15:0] w, input int nbits,
                                      input logic ld, input bit collide);
    if (collide && m_pend) begin
      m_code = m_hold; m_upd++; m_pend = 1'b0;
    end
    if (nbits != 16) m_err = 1'b1;
    else if (!ld || collide) begin
      m_code = w; m_upd++; m_pend = 1'b0;
    end else begin
      m_hold = w; m_pend = 1'b1;
    end
  endfunction

  function automatic void model_release();
    if (m_pend) begin
      m_code = m_hold; m_upd++; m_pend = 1'b0;
    end
  endfunction

  task automatic send_frame(input logic [15:0] w, input int nbits, input logic ld,
                            input bit collide);
    load_n = ld;
    sel_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? w[15-i] : 1'b1;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    sel_n = 1'b1;
    if (collide) load_n = 1'b0;
    wait_clk(10);
    model_close(w, nbits, ld, collide);
    if (collide) begin
      load_n = 1'b1;
      wait_clk(4);
    end
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(10);
    model_release();
    load_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0D1C));
    wait_clk(5);
    check("R1 code in reset", 32'(dac_code), 32'h0);
    check("R1 update in reset", 32'(dac_update), 32'h0);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R1 after reset");

    // R2 R3: three-wire load, MSB first
    send_frame(16'hA5C3, 16, 1'b0, 1'b0);
    check_all("R2 R3 direct A5C3");
    send_frame(16'h8001, 16, 1'b0, 1'b0);
    check_all("R2 bit order 8001");

    // R10: clock toggles with select high
    ser_din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    end
    check_all("R10 idle clocks");
    send_frame(16'h0F0F, 16, 1'b0, 1'b0);
    check_all("R10 frame after idle clocks");

    // R5: deferred update
    send_frame(16'h1234, 16, 1'b1, 1'b0);
    check_all("R5 pending holds latch");
    pulse_load();
    check_all("R5 release");

    // R6: newer word replaces pending
    send_frame(16'h1111, 16, 1'b1, 1'b0);
    send_frame(16'h2222, 16, 1'b1, 1'b0);
    check_all("R6 before release");
    pulse_load();
    check_all("R6 newest applied");

    // R7: load fall with nothing pending
    pulse_load();
    check_all("R7 no pending");
    // R7: load fall while the frame select is low
    send_frame(16'h3333, 16, 1'b1, 1'b0);
    load_n = 1'b1; sel_n = 1'b0; wait_clk(4);
    load_n = 1'b0; wait_clk(8); load_n = 1'b1; wait_clk(4);
    check_all("R7 fall during frame");
    sel_n = 1'b1; wait_clk(10);
    model_close(16'h0, 0, 1'b1, 1'b0);
    m_err = 1'b0;
    check("R7 code after empty frame", 32'(dac_code), 32'(m_code));

    // The empty frame above was a bad frame; resync the model by resetting.
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    m_code = '0; m_pend = 1'b0; m_err = 1'b0; m_upd = 0; upd_seen = 0;
    check_all("R1 second reset");

    // R9: coincident release and load fall
    send_frame(16'h4444, 16, 1'b1, 1'b1);
    check_all("R9 collide no pending");
    send_frame(16'h5555, 16, 1'b1, 1'b0);
    send_frame(16'h6666, 16, 1'b1, 1'b1);
    check_all("R9 collide with pending");

    // R4: short and long frames
    send_frame(16'h7777, 15, 1'b0, 1'b0);
    check_all("R4 short frame");
    send_frame(16'h7777, 17, 1'b0, 1'b0);
    check_all("R4 long frame");
    send_frame(16'h9999, 16, 1'b0, 1'b0);
    check_all("R4 flag sticky after good frame");

    // Random mix, R8 via update counting
    for (int n = 0; n < 40; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) begin
        int nb;
        nb = ($urandom % 2) ? int'($urandom % 15) + 1 : 17 + int'($urandom % 4);
        send_frame(16'($urandom), nb, 1'($urandom), 1'b0);
      end else if (r < 4) begin
        pulse_load();
      end else begin
        send_frame(16'($urandom), 16, 1'($urandom), 1'b0);
      end
      check_all("R8 random step");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule